// File: doc/BRIEF.md
# Branch Flush Controller

This block steers a six-stage in-order pipeline whose stages are fetch, decode, operand calculation, operand fetch, execute and write. It keeps one valid bit per stage and carries a branch marker alongside each valid instruction. Fetch follows a predict-not-taken policy: the fetch address advances by one each cycle, and a branch that turns out not taken costs nothing.

Conditional branches resolve late, at the end of execute. A taken outcome redirects fetch to the supplied target in the next cycle. It also squashes the younger instructions that were fetched on the wrong path. Without a delay slot this means four instructions. When the delay slot is enabled, the instruction directly behind the branch is kept, so only three are squashed. If software has nothing useful for the slot, it places a no-operation there. A saturating counter accumulates the bubble cycles that the flushes cost.

The sequencer is a two-state machine. In `ST_RUN` it accepts resolutions. A taken resolution in a valid branch in execute is the transition RUN→DRAIN. `ST_DRAIN` lasts four cycles, while the squashed slots pass execute, and then takes the transition DRAIN→RUN. Synchronous reset forces `ST_RUN`.

Top module: `brflush_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, every stage valid bit is 0, the fetch address equals RESET_VEC (default 0x0100), the bubble total is 0 and no kill bit is set.
- R2: After reset is released, the fetch stage becomes valid on the first clock edge. The fetch address then holds RESET_VEC for that first cycle and increments by one on each later cycle without a redirect.
- R3: Stage bits are ordered bit0=fetch, bit1=decode, bit2=operand calculation, bit3=operand fetch, bit4=execute, bit5=write. With no kill, each valid bit moves up one position per cycle and bit0 is refilled with 1.
- R4: When execute holds a valid branch, the outcome is taken and the delay slot is disabled, kill bits 0 to 3 (kill = 0x0F) are set in that same cycle. The fetch address equals the target in the following cycle.
- R5: A valid branch in execute that resolves not taken sets no kill bit, causes no redirect and leaves the bubble total unchanged.
- R6: With the delay slot enabled, a taken branch sets only kill bits 0 to 2 (kill = 0x07). The instruction in operand fetch proceeds to execute in the next cycle.
- R7: A stage whose kill bit is set delivers an invalid slot to the next stage, so the squashed instruction never reaches write.
- R8: The taken input is ignored when execute holds no valid branch and during the four drain cycles that follow a redirect. Kill bits are only ever set on valid stages.
- R9: Each flush adds 4 to the bubble total, or 3 when the delay slot is enabled. The total saturates at 2^PW-1 (255 by default) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_br | input | 1 | Marks the instruction now in fetch as a conditional branch |
| slot_en | input | 1 | Enables the single delay slot after a branch |
| ei_taken | input | 1 | Resolved outcome of the branch in execute (1 = taken) |
| br_target | input | AW | Target address of the branch in execute |
| fetch_pc | output | AW | Address of the instruction in the fetch stage |
| stage_valid | output | 6 | Valid bit per stage, bit0 fetch to bit5 write |
| stage_kill | output | 6 | Squash request per stage for this cycle |
| bubble_total | output | PW | Saturating count of bubble cycles caused by flushes |

## Verification
The properties assume that the instruction in a delay slot is never itself a branch. They also assume that the taken and target inputs are meaningful only in the cycle a marked branch sits in execute, although the block must tolerate any value on them at other times. The stimulus marks only chosen instructions as branches and keeps every branch out of a slot position. It deliberately raises the taken input while execute holds a bubble or a non-branch instruction. The saturation run marks every fetched instruction as a branch and holds taken high, so flushes occur every five cycles with the delay slot off.

// File: rtl/brflush_pkg.sv
package brflush_pkg;

    // stage positions; the execute position sets how many younger slots exist
    localparam int N_STG  = 6;
    localparam int STG_FI = 0;
    localparam int STG_DI = 1;
    localparam int STG_CO = 2;
    localparam int STG_FO = 3;
    localparam int STG_EI = 4;
    localparam int STG_WO = 5;

    // wrong-path slots behind a branch resolving in execute
    localparam int DRAIN_CYC = STG_EI - STG_FI;
    localparam int DRAIN_W   = $clog2(DRAIN_CYC);

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } flush_st_e;

endpackage

// File: rtl/brflush_pc.sv
module brflush_pc #(
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   RESET_VEC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_on,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= RESET_VEC;
        end else if (redirect) begin
            pc <= target;
        end else if (fetch_on) begin
            pc <= pc + AW'(1);
        end
    end

endmodule

// File: rtl/brflush_track.sv
module brflush_track
    import brflush_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_br,
    input  logic [N_STG-1:0] kill,
    output logic [N_STG-1:0] valid,
    output logic [N_STG-1:0] is_br
);

    logic [N_STG-1:0] br_q;

    // fetch slot: refilled every cycle once out of reset
    always_ff @(posedge clk) begin
        if (rst) begin
            valid[STG_FI] <= 1'b0;
        end else begin
            valid[STG_FI] <= 1'b1;
        end
    end

    assign br_q[STG_FI]  = fetch_br;
    assign is_br[STG_FI] = fetch_br & valid[STG_FI];

    genvar gi;
    generate
        for (gi = 1; gi < N_STG; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    valid[gi] <= 1'b0;
                    br_q[gi]  <= 1'b0;
                end else begin
                    valid[gi] <= valid[gi-1] & ~kill[gi-1];
                    br_q[gi]  <= is_br[gi-1] & ~kill[gi-1];
                end
            end
            assign is_br[gi] = br_q[gi] & valid[gi];
        end
    endgenerate

endmodule

// File: rtl/brflush_seq.sv
module brflush_seq
    import brflush_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ei_branch,
    input  logic             ei_taken,
    input  logic             slot_en,
    output logic             redirect,
    output logic [N_STG-1:0] kill,
    output logic [PW-1:0]    bubbles
);

    localparam logic [PW-1:0]     PEN_MAX = {PW{1'b1}};
    localparam logic [DRAIN_W-1:0] CNT_TOP = DRAIN_W'(DRAIN_CYC - 1);

    flush_st_e            state, state_nx;
    logic [DRAIN_W-1:0]   cnt, cnt_nx;
    logic [N_STG-1:0]     span_full, span_slot, span;
    logic [PW:0]          pen_sum;
    logic [PW-1:0]        pen_step;

    // squash masks: every stage younger than execute, or all but the slot
    genvar gi;
    generate
        for (gi = 0; gi < N_STG; gi++) begin : g_span
            assign span_full[gi] = (gi < STG_EI);
            assign span_slot[gi] = (gi < STG_EI - 1);
        end
    endgenerate

    assign span     = slot_en ? span_slot : span_full;
    assign pen_step = slot_en ? PW'(DRAIN_CYC - 1) : PW'(DRAIN_CYC);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        redirect = 1'b0;
        kill     = '0;
        unique case (state)
            ST_RUN: begin
                if (ei_branch && ei_taken) begin
                    redirect = 1'b1;
                    kill     = span;
                    state_nx = ST_DRAIN;
                    cnt_nx   = CNT_TOP;
                end
            end
            ST_DRAIN: begin
                if (cnt == '0) begin
                    state_nx = ST_RUN;
                end else begin
                    cnt_nx = cnt - DRAIN_W'(1);
                end
            end
            default: begin
                state_nx = ST_RUN;
            end
        endcase
    end

    // saturating bubble accumulator
    assign pen_sum = {1'b0, bubbles} + {1'b0, pen_step};

    always_ff @(posedge clk) begin
        if (rst) begin
            bubbles <= '0;
        end else if (redirect) begin
            bubbles <= pen_sum[PW] ? PEN_MAX : pen_sum[PW-1:0];
        end
    end

endmodule

// File: rtl/brflush_ctrl.sv
module brflush_ctrl
    import brflush_pkg::*;
#(
    parameter int            AW        = 16,
    parameter int            PW        = 8,
    parameter logic [AW-1:0] RESET_VEC = 16'h0100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_br,
    input  logic             slot_en,
    input  logic             ei_taken,
    input  logic [AW-1:0]    br_target,
    output logic [AW-1:0]    fetch_pc,
    output logic [N_STG-1:0] stage_valid,
    output logic [N_STG-1:0] stage_kill,
    output logic [PW-1:0]    bubble_total
);

    logic [N_STG-1:0] is_br;
    logic             redirect;

    brflush_track u_track (
        .clk      (clk),
        .rst      (rst),
        .fetch_br (fetch_br),
        .kill     (stage_kill),
        .valid    (stage_valid),
        .is_br    (is_br)
    );

    brflush_seq #(.PW(PW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ei_branch (is_br[STG_EI]),
        .ei_taken  (ei_taken),
        .slot_en   (slot_en),
        .redirect  (redirect),
        .kill      (stage_kill),
        .bubbles   (bubble_total)
    );

    brflush_pc #(.AW(AW), .RESET_VEC(RESET_VEC)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .fetch_on (stage_valid[STG_FI]),
        .redirect (redirect),
        .target   (br_target),
        .pc       (fetch_pc)
    );

endmodule

// File: rtl/brflush_ctrl_chk.sv
module brflush_ctrl_chk #(
    parameter int            AW        = 16,
    parameter int            PW        = 8,
    parameter logic [AW-1:0] RESET_VEC = 16'h0100
) (
    input logic          clk,
    input logic          rst,
    input logic          slot_en,
    input logic [AW-1:0] br_target,
    input logic [AW-1:0] fetch_pc,
    input logic [5:0]    stage_valid,
    input logic [5:0]    stage_kill,
    input logic [PW-1:0] bubble_total
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (stage_valid == '0 && bubble_total == '0 && fetch_pc == RESET_VEC));

    a_r2_sequential_fetch: assert property (@(posedge clk) disable iff (rst)
        (stage_kill == '0 && stage_valid[0]) |=> fetch_pc == $past(fetch_pc) + AW'(1));

    a_r3_advance: assert property (@(posedge clk) disable iff (rst)
        (stage_kill == '0) |=> (stage_valid[5:1] == $past(stage_valid[4:0]) && stage_valid[0]));

    a_r4_redirect: assert property (@(posedge clk) disable iff (rst)
        (stage_kill != '0) |=> fetch_pc == $past(br_target));

    a_r6_slot_kept: assert property (@(posedge clk) disable iff (rst)
        (stage_kill != '0 && slot_en) |=> stage_valid[4]);

    a_r4_no_slot_bubble: assert property (@(posedge clk) disable iff (rst)
        (stage_kill != '0 && !slot_en) |=> !stage_valid[4]);

    a_r7_squash_clears: assert property (@(posedge clk) disable iff (rst)
        (stage_kill != '0) |=> (stage_valid[4:1] & $past(stage_kill[3:0])) == '0);

    a_r8_kill_valid_only: assert property (@(posedge clk) disable iff (rst)
        (stage_kill & ~stage_valid) == '0);

    a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (stage_kill != '0) |=> stage_kill == '0);

    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (bubble_total == {PW{1'b1}}) |=> bubble_total == {PW{1'b1}});

    a_r9_steady: assert property (@(posedge clk) disable iff (rst)
        (stage_kill == '0) |=> $stable(bubble_total));

endmodule

bind brflush_ctrl brflush_ctrl_chk #(.AW(AW), .PW(PW), .RESET_VEC(RESET_VEC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .slot_en      (slot_en),
    .br_target    (br_target),
    .fetch_pc     (fetch_pc),
    .stage_valid  (stage_valid),
    .stage_kill   (stage_kill),
    .bubble_total (bubble_total)
);

// File: tb/brflush_ctrl_tb.sv
`timescale 1ns/1ps
module brflush_ctrl_tb;

    localparam int AW = 16;
    localparam int PW = 8;
    localparam int NROW = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fetch_br = 1'b0;
    logic          slot_en = 1'b0;
    logic          ei_taken = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [AW-1:0] fetch_pc;
    logic [5:0]    stage_valid;
    logic [5:0]    stage_kill;
    logic [PW-1:0] bubble_total;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    brflush_ctrl #(.AW(AW), .PW(PW), .RESET_VEC(16'h0100)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .fetch_br     (fetch_br),
        .slot_en      (slot_en),
        .ei_taken     (ei_taken),
        .br_target    (br_target),
        .fetch_pc     (fetch_pc),
        .stage_valid  (stage_valid),
        .stage_kill   (stage_kill),
        .bubble_total (bubble_total)
    );

    // row: br | taken | slot | target[16] | kill[6] | pc after[16] | valid after[6] | bubbles after[8]
    localparam logic [54:0] TBL [NROW] = '{
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0100,6'h01,8'd0},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0101,6'h03,8'd0},
        {1'b1,1'b0,1'b0,16'h0000,6'h00,16'h0102,6'h07,8'd0},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0103,6'h0F,8'd0},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0104,6'h1F,8'd0},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0105,6'h3F,8'd0},
        {1'b0,1'b1,1'b0,16'h0200,6'h0F,16'h0200,6'h21,8'd4},
        {1'b0,1'b1,1'b0,16'h0300,6'h00,16'h0201,6'h03,8'd4},
        {1'b1,1'b0,1'b0,16'h0000,6'h00,16'h0202,6'h07,8'd4},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0203,6'h0F,8'd4},
        {1'b1,1'b0,1'b0,16'h0000,6'h00,16'h0204,6'h1F,8'd4},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0205,6'h3F,8'd4},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0206,6'h3F,8'd4},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0207,6'h3F,8'd4},
        {1'b0,1'b1,1'b1,16'h0280,6'h07,16'h0280,6'h31,8'd7},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0281,6'h23,8'd7},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0282,6'h07,8'd7},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0283,6'h0F,8'd7},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0284,6'h1F,8'd7},
        {1'b0,1'b1,1'b0,16'h03F0,6'h00,16'h0285,6'h3F,8'd7},
        {1'b0,1'b0,1'b0,16'h0000,6'h00,16'h0286,6'h3F,8'd7}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(32'(stage_valid), 32'h0, "R1 valid in reset");
        chk(32'(fetch_pc), 32'h0100, "R1 pc in reset");
        chk(32'(bubble_total), 32'h0, "R1 bubbles in reset");
        chk(32'(stage_kill), 32'h0, "R1 kill in reset");

        @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < NROW; r++) begin
            fetch_br  = TBL[r][54];
            ei_taken  = TBL[r][53];
            slot_en   = TBL[r][52];
            br_target = TBL[r][51:36];
            #1;
            // R4 R5 R6 R8: kill in the resolving cycle
            chk(32'(stage_kill), 32'(TBL[r][35:30]), $sformatf("R4 R5 R6 R8 kill row %0d", r));
            @(posedge clk);
            #1;
            // R2 R4: fetch address
            chk(32'(fetch_pc), 32'(TBL[r][29:14]), $sformatf("R2 R4 pc row %0d", r));
            // R3 R7: stage occupancy
            chk(32'(stage_valid), 32'(TBL[r][13:8]), $sformatf("R3 R7 valid row %0d", r));
            // R5 R9: bubble count
            chk(32'(bubble_total), 32'(TBL[r][7:0]), $sformatf("R5 R9 bubbles row %0d", r));
            @(negedge clk);
        end

        // R1: reset in the middle of a run
        fetch_br = 1'b1; ei_taken = 1'b1; slot_en = 1'b0; br_target = 16'h0400;
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk(32'(stage_valid), 32'h0, "R1 valid after mid-run reset");
        chk(32'(fetch_pc), 32'h0100, "R1 pc after mid-run reset");
        chk(32'(bubble_total), 32'h0, "R1 bubbles after mid-run reset");
        chk(32'(stage_kill), 32'h0, "R1 kill during reset");

        // R9: every instruction a taken branch, flush every five cycles
        @(negedge clk);
        rst = 1'b0;
        repeat (400) @(posedge clk);
        #1;
        chk(32'(bubble_total), 32'd255, "R9 saturated total");
        repeat (20) @(posedge clk);
        #1;
        chk(32'(bubble_total), 32'd255, "R9 total holds at max");
        chk(32'(fetch_pc[15:8]), 32'h04, "R4 pc stays near target under repeated flushes");

        done = 1'b1;
        finish_run();
    end

endmodule